// File: doc/BRIEF.md
# Clock Frequency Select and Test Divider

This block sits between a three-bit frequency-select input and the output stage of a motherboard clock generator. It drives seven clock groups: processor, half-rate processor, graphics port, peripheral bus, USB, reference and interrupt controller. In normal operation it tells the output stage, for each group, whether that group is enabled, driven low or placed in high impedance. It also reports a three-bit frequency-class code. The synthesis of the clocks themselves happens elsewhere.

One select code puts the block in test mode. There it makes every group's clock by dividing the test clock applied to `clk_i`, and each group has its own fixed ratio. All divider phases come from one shared synchronous counter, so the divided clocks stay aligned with each other. A new select code is first captured in a register. It becomes active only on the clock edge where that shared counter wraps, which is the edge where every divided output has just finished a full low phase, so switching modes never cuts a clock pulse short.

Top module: `freqsel_testdiv`

## Requirements
- R1: While `rst_i` is high (synchronous, active high), the block shows the high-impedance state: `grp_hiz_o` = 7'h7F, `grp_en_o` = 0, `freq_o` = 0 and every registered divided clock is 0. Group bit positions in the vectors are 0 processor, 1 half-rate processor, 2 graphics, 3 peripheral, 4 USB, 5 reference, 6 interrupt controller.
- R2: Select code 000 gives `freq_o` = 0, `grp_hiz_o` = 7'h7F and `grp_en_o` = 0. No group is ever flagged enabled and high-impedance at once.
- R3: Select code 010 is test mode. It gives `freq_o` = 3, `grp_en_o` = 7'h7F and `grp_hiz_o` = 0. Each group's clock is the test clock divided by its own ratio: processor 2, half-rate 4, graphics 4, peripheral 8, USB 2, reference 1 and interrupt controller 16. The reference clock is the test clock passed through a gate.
- R4: In test mode, the divided clock of ratio 2^L (L ≥ 1), sampled after clock edge n, equals the inverse of bit L-1 of (n mod 16). Here n counts the edges since reset was released. This gives each divided clock a 50% duty cycle and makes every divided output rise on the same edge, whenever n mod 16 = 0.
- R5: Select code 011 is reserved. It gives `freq_o` = 7 with no group enabled and no group high-impedance.
- R6: Select codes 101 and 111 enable all seven groups with no high-impedance flag. `freq_o` is 1 (100 MHz class, half-rate output at 50 MHz) for 101 and 2 (133 MHz class, half-rate output at 66.67 MHz) for 111.
- R7: Select codes 100 and 110 give the same `freq_o` as 101 and 111 respectively, with every group enabled except USB (`grp_en_o` = 7'h6F).
- R8: Select code 001 gives `freq_o` = 1 with all groups enabled.
- R9: A select value driven before edge k is captured at edge k. It takes effect on the first edge n > k with n mod 16 = 0. Until that edge, all outputs keep the previous mode.
- R10: Outside test mode, every divided clock output, the gated reference clock included, stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock; also clocks all internal registers |
| rst_i | input | 1 | Synchronous active-high reset |
| sel_i | input | 3 | Frequency-select code (bit 2 high-speed, bits 1:0 mode) |
| freq_o | output | 3 | Frequency-class code of the active mode |
| grp_clk_o | output | 7 | Per-group divided test clock |
| grp_en_o | output | 7 | Per-group output enable |
| grp_hiz_o | output | 7 | Per-group high-impedance flag |

## Verification
If the shared counter has the wrong phase, the divided clocks stop lining up with the edge count since reset. The next sample after the mode takes effect shows this on the ratio-2 output, and within 16 edges every ratio shows it. A corrupted active-mode register is visible on the very next edge as a wrong `freq_o`, enable or high-impedance pattern. A fault in the change-timing logic shows up as the mode changing before or after the predicted 16-edge boundary, which the bench checks on the edges on both sides of that boundary.

// File: rtl/freqsel_pkg.sv
`timescale 1ns/1ps
package freqsel_pkg;
  localparam int unsigned NGRP = 7;
  localparam int unsigned SEL_W = 3;

  localparam int unsigned G_CPU  = 0;
  localparam int unsigned G_HALF = 1;
  localparam int unsigned G_GFX  = 2;
  localparam int unsigned G_PBUS = 3;
  localparam int unsigned G_USB  = 4;
  localparam int unsigned G_REF  = 5;
  localparam int unsigned G_IRQ  = 6;

  localparam logic [SEL_W-1:0] SEL_TEST = 3'b010;

  localparam logic [2:0] FC_HIZ  = 3'd0;
  localparam logic [2:0] FC_100  = 3'd1;
  localparam logic [2:0] FC_133  = 3'd2;
  localparam logic [2:0] FC_TEST = 3'd3;
  localparam logic [2:0] FC_RSV  = 3'd7;

  typedef struct packed {
    logic [2:0]      freq;
    logic [NGRP-1:0] en;
    logic [NGRP-1:0] hiz;
  } mode_t;

  function automatic mode_t decode_sel(input logic [SEL_W-1:0] s);
    mode_t m;
    m.freq = FC_HIZ;
    m.en   = '0;
    m.hiz  = '0;
    case (s)
      3'b000: m.hiz = '1;
      3'b001: begin m.freq = FC_100;  m.en = '1; end
      3'b010: begin m.freq = FC_TEST; m.en = '1; end
      3'b011: m.freq = FC_RSV;
      default: begin
        m.freq     = s[1] ? FC_133 : FC_100;
        m.en       = '1;
        m.en[G_USB] = s[0];
      end
    endcase
    return m;
  endfunction
endpackage

// File: rtl/freqsel_capture.sv
`timescale 1ns/1ps
module freqsel_capture
  import freqsel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             wrap_i,
  output logic [SEL_W-1:0] act_q_o,
  output logic [SEL_W-1:0] act_nx_o
);
  logic [SEL_W-1:0] sel_s;
  logic [SEL_W-1:0] act_q;

  assign act_nx_o = wrap_i ? sel_s : act_q;
  assign act_q_o  = act_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sel_s <= '0;
      act_q <= '0;
    end else begin
      sel_s <= sel_i;
      act_q <= act_nx_o;
    end
  end

  // R9
  act_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (act_q != $past(act_q)) |-> $past(wrap_i));
endmodule

// File: rtl/freqsel_decode.sv
`timescale 1ns/1ps
module freqsel_decode
  import freqsel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] act_nx_i,
  output logic [2:0]       freq_o,
  output logic [NGRP-1:0]  en_o,
  output logic [NGRP-1:0]  hiz_o
);
  mode_t nx;
  mode_t rst_mode;

  assign nx       = decode_sel(act_nx_i);
  assign rst_mode = decode_sel('0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      freq_o <= rst_mode.freq;
      en_o   <= rst_mode.en;
      hiz_o  <= rst_mode.hiz;
    end else begin
      freq_o <= nx.freq;
      en_o   <= nx.en;
      hiz_o  <= nx.hiz;
    end
  end

  // R2
  en_hiz_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_o & hiz_o) == '0);
endmodule

// File: rtl/freqsel_divider.sv
`timescale 1ns/1ps
module freqsel_divider
  import freqsel_pkg::*;
#(
  parameter int unsigned DIV_LOG2 [NGRP] = '{1, 2, 2, 3, 1, 0, 4}
)(
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            test_nx_i,
  input  logic            test_q_i,
  output logic            wrap_o,
  output logic [NGRP-1:0] clk_o
);
  function automatic int unsigned max_log2();
    int unsigned m = 1;
    for (int i = 0; i < NGRP; i++)
      if (DIV_LOG2[i] > m) m = DIV_LOG2[i];
    return m;
  endfunction

  localparam int unsigned CNT_W = max_log2();

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = cnt_q + 1'b1;
  assign wrap_o = &cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_nx;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    if (DIV_LOG2[g] == 0) begin : g_pass
      logic gate_q;
      always_ff @(negedge clk_i) begin
        if (rst_i) gate_q <= 1'b0;
        else       gate_q <= test_q_i;
      end
      assign clk_o[g] = clk_i & gate_q;
    end else begin : g_div
      logic div_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) div_q <= 1'b0;
        else       div_q <= test_nx_i & ~cnt_nx[DIV_LOG2[g]-1];
      end
      assign clk_o[g] = div_q;

      // R4
      edge_align_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (test_q_i && cnt_q == '0) |-> div_q);
      // R10
      quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !test_q_i |-> !div_q);
    end
  end
endmodule

// File: rtl/freqsel_testdiv.sv
`timescale 1ns/1ps
module freqsel_testdiv
  import freqsel_pkg::*;
#(
  parameter int unsigned DIV_LOG2 [NGRP] = '{1, 2, 2, 3, 1, 0, 4}
)(
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [2:0]      sel_i,
  output logic [2:0]      freq_o,
  output logic [6:0]      grp_clk_o,
  output logic [6:0]      grp_en_o,
  output logic [6:0]      grp_hiz_o
);
  logic [SEL_W-1:0] act_q;
  logic [SEL_W-1:0] act_nx;
  logic             wrap;
  logic             test_q;
  logic             test_nx;

  assign test_q  = (act_q  == SEL_TEST);
  assign test_nx = (act_nx == SEL_TEST);

  freqsel_capture u_capture (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .sel_i    (sel_i),
    .wrap_i   (wrap),
    .act_q_o  (act_q),
    .act_nx_o (act_nx)
  );

  freqsel_decode u_decode (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .act_nx_i (act_nx),
    .freq_o   (freq_o),
    .en_o     (grp_en_o),
    .hiz_o    (grp_hiz_o)
  );

  freqsel_divider #(.DIV_LOG2(DIV_LOG2)) u_divider (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .test_nx_i (test_nx),
    .test_q_i  (test_q),
    .wrap_o    (wrap),
    .clk_o     (grp_clk_o)
  );
endmodule

// File: tb/test_freqsel_testdiv.sv
`timescale 1ns/1ps
module test_freqsel_testdiv;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel = 3'b000;
  logic [2:0] freq;
  logic [6:0] gclk, gen, ghiz;

  int unsigned ncyc = 0;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [2:0] cur_freq = 3'd0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) ncyc <= 0;
    else     ncyc <= ncyc + 1;
  end

  freqsel_testdiv i_freqsel_testdiv (
    .clk_i(clk), .rst_i(rst), .sel_i(sel),
    .freq_o(freq), .grp_clk_o(gclk), .grp_en_o(gen), .grp_hiz_o(ghiz)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at edge %0d: actual %0h expected %0h", req, ncyc, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk_mode(input string req, input logic [2:0] f,
                          input logic [6:0] e, input logic [6:0] h);
    chk({req, " freq"}, 32'(freq), 32'(f));
    chk({req, " en"},   32'(gen),  32'(e));
    chk({req, " hiz"},  32'(ghiz), 32'(h));
  endtask

  // R9: drive code, confirm old mode one edge before the 16-edge boundary, new at it
  task automatic switch_mode(input logic [2:0] code, input logic [2:0] new_freq,
                             output int unsigned n_ap);
    int unsigned k;
    k = ncyc;
    n_ap = ((k + 2 + 15) / 16) * 16;
    sel = code;
    while (ncyc < n_ap - 1) tick();
    chk("R9 old mode held", 32'(freq), 32'(cur_freq));
    tick();
    chk("R9 new mode at boundary", 32'(freq), 32'(new_freq));
    cur_freq = new_freq;
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk_mode("R1 reset", 3'd0, 7'h00, 7'h7F);
    chk("R1 reset clocks", 32'(gclk & 7'h5F), 32'd0);
    rst = 1'b0;
    tick();
    chk_mode("R2 idle 000", 3'd0, 7'h00, 7'h7F);
  endtask

  task automatic t_normal(input logic [2:0] code, input logic [2:0] f,
                          input logic [6:0] e, input string req);
    int unsigned n_ap;
    switch_mode(code, f, n_ap);
    chk_mode(req, f, e, 7'h00);
    repeat (5) begin
      tick();
      chk("R10 clocks quiet", 32'(gclk), 32'd0);
    end
  endtask

  task automatic t_test();
    int unsigned n_ap;
    int unsigned lg [7] = '{1, 2, 2, 3, 1, 0, 4};
    logic exp_b;
    switch_mode(3'b010, 3'd3, n_ap);
    chk_mode("R3 test mode", 3'd3, 7'h7F, 7'h00);
    for (int c = 0; c < 34; c++) begin
      for (int g = 0; g < 7; g++) begin
        if (lg[g] == 0) exp_b = (ncyc > n_ap);
        else            exp_b = ~(((ncyc % 16) >> (lg[g] - 1)) & 1);
        chk($sformatf("R3 R4 group %0d divided clock", g), 32'(gclk[g]), 32'(exp_b));
      end
      if ((ncyc % 16) == 0) chk("R4 common rising edge", 32'(gclk & 7'h5F), 32'h5F);
      tick();
    end
    @(negedge clk); #5;
    chk("R3 reference low in clock low phase", 32'(gclk[5]), 32'd0);
    tick();
  endtask

  task automatic t_exit_test();
    int unsigned n_ap;
    switch_mode(3'b000, 3'd0, n_ap);
    chk_mode("R2 all high impedance", 3'd0, 7'h00, 7'h7F);
    tick();
    repeat (4) begin
      tick();
      chk("R10 clocks low after test", 32'(gclk), 32'd0);
    end
  endtask

  initial begin
    t_reset();
    t_normal(3'b101, 3'd1, 7'h7F, "R6 code 101");
    t_normal(3'b111, 3'd2, 7'h7F, "R6 code 111");
    t_normal(3'b100, 3'd1, 7'h6F, "R7 code 100");
    t_normal(3'b110, 3'd2, 7'h6F, "R7 code 110");
    t_normal(3'b001, 3'd1, 7'h7F, "R8 code 001");
    t_normal(3'b011, 3'd7, 7'h00, "R5 reserved 011");
    t_test();
    t_exit_test();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule